// File: doc/BRIEF.md
# Cascadable Binary Rate Multiplier

The block turns a clock into a train of pulses whose average rate is a chosen fraction m/64 of the clock rate. A six-bit up-counter runs through 64 states. A decoder derives six gating windows from the counter, and the windows never overlap. The widest window is open on every second clock, the next on every fourth, and so on down to one clock in 64. A six-bit select word chooses which windows may pass a clock period to the output. The output therefore carries m = 32·sel[5] + 16·sel[4] + 8·sel[3] + 4·sel[2] + 2·sel[1] + sel[0] pulses in each run of 64 enabled clocks. The pulses are evenly spaced only when m is a power of two. For other values the output interleaves the trains of several windows.

The block has two pulse outputs. The Z output is gated by the clock and rests HIGH. The Y output rests LOW and has its own gate input. A synchronous per-cycle flag marks the clock periods that carry a pulse. An active-low terminal-count output lets two instances form a 12-bit multiplier. In that arrangement the first stage's terminal count drives the second stage's count enable and Z gate, and the first stage's Z output drives the second stage's Y gate. The combined train is taken from the second stage's Y output and carries 64·m_first + m_second pulses in every 4096 clocks.

Top module: `rate_mult`

## Requirements
- R1: On each rising clock edge the counter increments modulo 64 while `cnt_en_n` is LOW. It keeps its value while `cnt_en_n` is HIGH.
- R2: `tc_n` is LOW exactly when the count is 63 and `cnt_en_n` is LOW. It is HIGH otherwise.
- R3: While `mclr` is HIGH the count is cleared at once, without waiting for a clock edge, and it stays at 0. Because count 0 opens the rate_sel[5] window, pulses still occur in this state when `zgate_n` is LOW and rate_sel[5] is HIGH.
- R4: Window k belongs to rate_sel[k]. It is open when count bit (5-k) is 0 and every count bit below that bit is 1. At most one window is open at a time, and no window is open at count 63.
- R5: `pulse_en` is HIGH when `zgate_n` is LOW and the open window's select bit is HIGH. Over any 64 clocks with counting enabled, `pulse_en` is HIGH in exactly m cycles, for every select value from 0 to 63.
- R6: `z_out` is HIGH while the clock is HIGH. While the clock is LOW, `z_out` is the inverse of `pulse_en`.
- R7: `y_out` equals NOT(`z_out` AND `ygate`). It rests LOW, and a LOW on `ygate` forces it HIGH.
- R8: Two instances cascaded as described pass 64·m_first + m_second clock-low pulses on the second stage's `y_out` in every 4096 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The counter advances on the rising edge. |
| mclr | input | 1 | Asynchronous master clear, active HIGH |
| cnt_en_n | input | 1 | Count enable, active LOW |
| rate_sel | input | 6 | Rate select word; bit k weighs 2^k |
| zgate_n | input | 1 | Z output gate, active LOW |
| ygate | input | 1 | Y output gate; LOW forces `y_out` HIGH |
| z_out | output | 1 | Pulse output, LOW during pulsed clock-low phases |
| y_out | output | 1 | NOT(z_out AND ygate) |
| tc_n | output | 1 | Terminal count, active LOW |
| pulse_en | output | 1 | Synchronous flag for a pulsed cycle |

## Verification
The clocked properties assume that `mclr` is HIGH before the first rising edge and that the control inputs stay settled through each rising edge. The bench drives new values only in the clock-low phase, once the previous phase has been sampled. The reset-hold property treats `mclr` as a level sampled at the edge. The bench's asynchronous clear therefore begins in the low phase and covers at least one full edge. The `z_out` and `y_out` values that depend on the clock level are compared only after the inputs have settled in each half period, so no check falls on a glitch caused by an input change.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int RM_WIDTH = 6;
  localparam int RM_STATES = 1 << RM_WIDTH;
endpackage

// File: rtl/rm_counter.sv
module rm_counter #(
  parameter int W = rm_pkg::RM_WIDTH
) (
  input  logic         clk,
  input  logic         mclr,
  input  logic         adv_n,
  output logic [W-1:0] cnt_q,
  output logic         at_top
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or posedge mclr) begin
    if (mclr) begin
      cnt_q <= '0;
    end else if (!adv_n) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_top = &cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (mclr)
    adv_n |=> $stable(cnt_q)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (mclr)
    !adv_n |=> cnt_q == W'($past(cnt_q) + 1'b1)); // R1
  AST_CLR_HOLD: assert property (@(posedge clk)
    mclr |-> cnt_q == '0); // R3
endmodule

// File: rtl/rm_window_dec.sv
module rm_window_dec #(
  parameter int W = rm_pkg::RM_WIDTH
) (
  input  logic [W-1:0] cnt,
  output logic [W-1:0] win
);
  for (genvar k = 0; k < W; k++) begin : g_win
    localparam int J = W - 1 - k;
    if (J == 0) begin : g_lsb
      assign win[k] = ~cnt[0];
    end else begin : g_upper
      assign win[k] = ~cnt[J] & (&cnt[J-1:0]);
    end
  end
endmodule

// File: rtl/rm_out_gate.sv
module rm_out_gate #(
  parameter int W = rm_pkg::RM_WIDTH
) (
  input  logic         clk,
  input  logic [W-1:0] win,
  input  logic [W-1:0] sel,
  input  logic         zen_n,
  input  logic         yen,
  output logic         pulse,
  output logic         z,
  output logic         y
);
  always_comb begin
    pulse = ~zen_n & (|(win & sel));
    z     = ~(pulse & ~clk);
    y     = ~(z & yen);
  end
endmodule

// File: rtl/rate_mult.sv
module rate_mult #(
  parameter int W = rm_pkg::RM_WIDTH
) (
  input  logic         clk,
  input  logic         mclr,
  input  logic         cnt_en_n,
  input  logic [W-1:0] rate_sel,
  input  logic         zgate_n,
  input  logic         ygate,
  output logic         z_out,
  output logic         y_out,
  output logic         tc_n,
  output logic         pulse_en
);
  logic [W-1:0] cnt;
  logic [W-1:0] win;
  logic         at_top;

  rm_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .mclr   (mclr),
    .adv_n  (cnt_en_n),
    .cnt_q  (cnt),
    .at_top (at_top)
  );

  rm_window_dec #(.W(W)) u_dec (
    .cnt (cnt),
    .win (win)
  );

  rm_out_gate #(.W(W)) u_gate (
    .clk   (clk),
    .win   (win),
    .sel   (rate_sel),
    .zen_n (zgate_n),
    .yen   (ygate),
    .pulse (pulse_en),
    .z     (z_out),
    .y     (y_out)
  );

  assign tc_n = ~(at_top & ~cnt_en_n);

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (mclr)
    $onehot0(win)); // R4
  AST_TOP_SILENT: assert property (@(posedge clk) disable iff (mclr)
    !tc_n |-> !pulse_en); // R4
  AST_ZGATE_MUTE: assert property (@(posedge clk) disable iff (mclr)
    zgate_n |-> !pulse_en); // R5
  AST_TC_IDLE: assert property (@(posedge clk) disable iff (mclr)
    cnt_en_n |-> tc_n); // R2
endmodule

// File: tb/rate_mult_tb.sv
`timescale 1ns/1ps
module rate_mult_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       mclr, ce_n, zen_n, yen;
  logic [5:0] sel;
  logic       z, y, tcn, pe;

  rate_mult u_dut (
    .clk(clk), .mclr(mclr), .cnt_en_n(ce_n), .rate_sel(sel),
    .zgate_n(zen_n), .ygate(yen), .z_out(z), .y_out(y),
    .tc_n(tcn), .pulse_en(pe)
  );

  // cascade pair: hi stage clocks continuously, lo stage enabled by hi terminal count
  logic [5:0] sel_a, sel_b;
  logic       z_a, y_a, tc_a, pe_a, z_b, y_b, tc_b, pe_b;

  rate_mult u_hi (
    .clk(clk), .mclr(mclr), .cnt_en_n(1'b0), .rate_sel(sel_a),
    .zgate_n(1'b0), .ygate(1'b1), .z_out(z_a), .y_out(y_a),
    .tc_n(tc_a), .pulse_en(pe_a)
  );
  rate_mult u_lo (
    .clk(clk), .mclr(mclr), .cnt_en_n(tc_a), .rate_sel(sel_b),
    .zgate_n(tc_a), .ygate(z_a), .z_out(z_b), .y_out(y_b),
    .tc_n(tc_b), .pulse_en(pe_b)
  );

  int vecs  = 0;
  int fails = 0;
  int mcnt  = 0;
  int casc_hits = 0;
  logic last_pe;

  function automatic logic ref_pulse(int c, logic [5:0] s, logic zn);
    if (zn || c == 63) return 1'b0;
    for (int j = 0; j < 6; j++) begin
      if (c[j] == 1'b0) return s[5-j];
    end
    return 1'b0;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic low_phase_checks();
    logic ep;
    logic ez;
    ep = ref_pulse(mcnt, sel, zen_n);
    ez = ~ep;
    chk("R5", "pulse_en", pe, ep);
    chk("R2", "tc_n", tcn, ~((mcnt == 63) && !ce_n));
    chk("R6", "z_out low phase", z, ez);
    chk("R7", "y_out low phase", y, ~(ez & yen));
  endtask

  // one clock: model update at the edge, high-phase and low-phase comparisons
  task automatic cycle();
    @(posedge clk);
    if (mclr) mcnt = 0;
    else if (!ce_n) mcnt = (mcnt + 1) % 64;
    #1;
    chk("R6", "z_out high phase", z, 1'b1);
    chk("R7", "y_out high phase", y, ~yen);
    @(negedge clk);
    #0.5;
    low_phase_checks();
    last_pe = pe;
    if (y_b) casc_hits++;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    int hits;
    int pa, pb;
    mclr = 1'b1; ce_n = 1'b1; zen_n = 1'b1; yen = 1'b1; sel = 6'd0;
    sel_a = 6'd0; sel_b = 6'd0;
    // R3 reset state
    repeat (3) cycle();
    // R3: pulses continue while cleared when S5 selected and Z gate open
    zen_n = 1'b0; sel = 6'b100000;
    repeat (3) cycle();
    chk("R3", "pulse during clear", pe, 1'b1);
    sel = 6'b011111;
    cycle();
    chk("R3", "other windows shut during clear", pe, 1'b0);
    // R1/R4/R5 running with mixed select
    mclr = 1'b0; ce_n = 1'b0; sel = 6'b101101;
    repeat (70) cycle();
    // R1 hold
    ce_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sel = 6'(i * 7);
      cycle();
    end
    // R5 Z gate closed, R7 Y gate low
    ce_n = 1'b0; zen_n = 1'b1; sel = 6'h3f;
    repeat (10) cycle();
    zen_n = 1'b0; yen = 1'b0;
    repeat (10) cycle();
    yen = 1'b1;
    // R2/R3: reach count 63 then clear asynchronously
    while (mcnt != 62) cycle();
    cycle();
    chk("R2", "tc_n at 63", tcn, 1'b0);
    chk("R4", "no pulse at 63", pe, 1'b0);
    mclr = 1'b1;
    #0.3;
    mcnt = 0;
    chk("R3", "async clear releases tc_n", tcn, 1'b1);
    chk("R3", "async clear reopens S5 window", pe, 1'b1);
    cycle();
    mclr = 1'b0;
    // R5 rate sweep over every select value
    for (int m = 0; m < 64; m++) begin
      sel = 6'(m);
      hits = 0;
      for (int k = 0; k < 64; k++) begin
        cycle();
        if (last_pe) hits++;
      end
      chk_int("R5", $sformatf("pulses per 64 for m=%0d", m), hits, m);
    end
    // R8 cascade
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: begin pa = 5;  pb = 3;  end
        1: begin pa = 63; pb = 63; end
        2: begin pa = 0;  pb = 1;  end
        default: begin pa = 32; pb = 0; end
      endcase
      sel_a = 6'(pa); sel_b = 6'(pb);
      casc_hits = 0;
      repeat (4096) cycle();
      chk_int("R8", $sformatf("cascade pulses mA=%0d mB=%0d", pa, pb),
              casc_hits, 64 * pa + pb);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule